// File: doc/BRIEF.md
# Microcoded Operate Instruction Unit

This unit executes the operate class of a 12-bit accumulator machine, the instructions whose opcode field is octal 7. Each bit of an operate word enables one small action, and several bits may be set together. Their actions then run in a fixed internal order within a single instruction. The sequencer pulses `issue` with the instruction word, the current accumulator, the link bit and the front-panel switch word. One clock later the unit presents the new accumulator and link, together with one-cycle skip, halt and unimplemented indications.

Instruction bits are numbered here by their weight: `instr[11]` is the most significant. The first group rotates and increments the 13-bit quantity formed by the link (on top) and the accumulator. The second group tests conditions and either skips on any of them or skips only when none of them holds. It can also clear the accumulator, merge the switches into it and stop the machine. The third operate group belongs to an optional arithmetic extension. It is recognised and reported as unimplemented, and it leaves the state untouched.

Top module: `opr_unit`

## Requirements
- R1: While `rst_n` is low, `acc_out` and `link_out` are zero and `skip`, `halt`, `unimpl` and `done` are low.
- R2: Results for an instruction presented with `issue` high appear on the first rising edge, with `done` high for exactly that cycle. In a cycle after `issue` was low, `done`, `skip`, `halt` and `unimpl` are low and `acc_out`/`link_out` keep their previous values.
- R3: Decode: `instr[11:9]` = 3'b111 marks an operate word. `instr[8]`=0 selects the first group. `instr[8]`=1 with `instr[0]`=0 selects the second group. `instr[8]`=1 with `instr[0]`=1 (third group) raises `unimpl` and passes accumulator and link through without skip or halt. Any other opcode passes them through with every flag low.
- R4: First group, step one: `instr[7]` clears the accumulator and `instr[6]` clears the link.
- R5: First group, step two, after the clears: `instr[5]` inverts every accumulator bit and `instr[4]` inverts the link (so 7240 yields 7777).
- R6: First group, step three: `instr[0]` adds one to the accumulator modulo 4096, and a carry out of the top bit inverts the link.
- R7: First group, last step: `instr[3]` rotates {link, accumulator} right by one position and `instr[2]` rotates it left by one. With `instr[1]` also set, the rotate moves two positions.
- R8: First group: `instr[1]` without either rotate bit exchanges the upper and lower 6-bit halves of the accumulator. When both `instr[3]` and `instr[2]` are set, no rotate or exchange happens.
- R9: Second group with `instr[3]`=0: skip when any selected test holds. `instr[6]` tests for accumulator bit 11 set, `instr[5]` tests for an all-zero accumulator and `instr[4]` tests for a set link.
- R10: Second group with `instr[3]`=1: skip only when none of the selected tests holds. With no test selected, the skip is unconditional (7410).
- R11: Second group: the tests use the incoming accumulator. After them, `instr[7]` clears the accumulator and then `instr[2]` ORs the switch word into it. The link is never changed.
- R12: `halt` rises only for a second-group word with `instr[1]` set. First-group words never skip or halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Execute the presented word this cycle |
| instr | input | 12 | Instruction word |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| switches | input | 12 | Front-panel switch word |
| acc_out | output | 12 | Updated accumulator |
| link_out | output | 1 | Updated link bit |
| skip | output | 1 | Advance the program counter by one extra word |
| halt | output | 1 | Stop request |
| unimpl | output | 1 | Third-group word seen, not executed |
| done | output | 1 | Results valid this cycle |

## Verification
The unit's only state is its output registers. A wrong sub-step order or a wrong decode therefore shows up in the very next cycle as a wrong accumulator, link or flag value. A skip or halt that persists past its cycle shows up as a flag high while `done` is low. The stimulus pairs each corner case with a word where a different ordering of the same bits would give a different result. The examples are clear-then-complement, complement-then-increment and test-then-clear.

// File: rtl/opr_pkg.sv
package opr_pkg;
  parameter int unsigned DATA_W = 12;
  localparam int unsigned INSTR_W = 12;
  localparam int unsigned ROT_W = DATA_W + 1;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam logic [2:0] OPR_OPCODE = 3'b111;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_ONE   = 2'd1,
    GRP_TWO   = 2'd2,
    GRP_THREE = 2'd3
  } opr_grp_e;

  typedef struct packed {
    logic clr_acc;
    logic clr_link;
    logic cpl_acc;
    logic cpl_link;
    logic rot_r;
    logic rot_l;
    logic twice;
    logic incr;
  } g1_ctl_t;

  typedef struct packed {
    logic clr_acc;
    logic sel_neg;
    logic sel_zero;
    logic sel_link;
    logic invert;
    logic or_sw;
    logic stop;
  } g2_ctl_t;

  function automatic opr_grp_e grp_of(input logic [INSTR_W-1:0] ir);
    opr_grp_e g;
    if (ir[INSTR_W-1 -: 3] != OPR_OPCODE) g = GRP_NONE;
    else if (!ir[8])                      g = GRP_ONE;
    else if (!ir[0])                      g = GRP_TWO;
    else                                  g = GRP_THREE;
    return g;
  endfunction

  function automatic g1_ctl_t g1_fields(input logic [INSTR_W-1:0] ir);
    g1_ctl_t c;
    c.clr_acc  = ir[7];
    c.clr_link = ir[6];
    c.cpl_acc  = ir[5];
    c.cpl_link = ir[4];
    c.rot_r    = ir[3];
    c.rot_l    = ir[2];
    c.twice    = ir[1];
    c.incr     = ir[0];
    return c;
  endfunction

  function automatic g2_ctl_t g2_fields(input logic [INSTR_W-1:0] ir);
    g2_ctl_t c;
    c.clr_acc  = ir[7];
    c.sel_neg  = ir[6];
    c.sel_zero = ir[5];
    c.sel_link = ir[4];
    c.invert   = ir[3];
    c.or_sw    = ir[2];
    c.stop     = ir[1];
    return c;
  endfunction

  // {carry, sum} of acc + 1
  function automatic logic [DATA_W:0] inc_carry(input logic [DATA_W-1:0] a);
    return {1'b0, a} + {{DATA_W{1'b0}}, 1'b1};
  endfunction

  function automatic logic [ROT_W-1:0] rot_right(input logic [ROT_W-1:0] v,
                                                 input logic two);
    return two ? {v[1:0], v[ROT_W-1:2]} : {v[0], v[ROT_W-1:1]};
  endfunction

  function automatic logic [ROT_W-1:0] rot_left(input logic [ROT_W-1:0] v,
                                                input logic two);
    return two ? {v[ROT_W-3:0], v[ROT_W-1 -: 2]} : {v[ROT_W-2:0], v[ROT_W-1]};
  endfunction
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output opr_grp_e           grp,
  output g1_ctl_t            g1,
  output g2_ctl_t            g2
);
  always_comb begin
    grp = grp_of(instr);
    g1  = g1_fields(instr);
    g2  = g2_fields(instr);
  end
endmodule

// File: rtl/opr_group1.sv
module opr_group1
  import opr_pkg::*;
(
  input  g1_ctl_t           ctl,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              link_o
);
  // named sub-step results
  logic [DATA_W-1:0] clr_acc_w, cpl_acc_w, inc_acc_w, swap_acc_w;
  logic              clr_link_w, cpl_link_w, inc_link_w;
  logic              inc_carry_w;
  logic [ROT_W-1:0]  pre_rot_w, post_rot_w;

  // step 1: clears
  assign clr_acc_w  = ctl.clr_acc  ? '0   : acc_i;
  assign clr_link_w = ctl.clr_link ? 1'b0 : link_i;

  // step 2: complements
  assign cpl_acc_w  = ctl.cpl_acc  ? ~clr_acc_w  : clr_acc_w;
  assign cpl_link_w = ctl.cpl_link ? ~clr_link_w : clr_link_w;

  // step 3: increment
  always_comb begin
    logic [DATA_W:0] sum;
    sum         = inc_carry(cpl_acc_w);
    inc_carry_w = ctl.incr & sum[DATA_W];
    inc_acc_w   = ctl.incr ? sum[DATA_W-1:0] : cpl_acc_w;
    inc_link_w  = cpl_link_w ^ inc_carry_w;
  end

  // halves exchange
  for (genvar b = 0; b < DATA_W; b++) begin : g_swap
    assign swap_acc_w[b] = inc_acc_w[(b + HALF_W) % DATA_W];
  end

  // step 4: rotates
  assign pre_rot_w = {inc_link_w, inc_acc_w};
  always_comb begin
    unique case ({ctl.rot_r, ctl.rot_l})
      2'b10:   post_rot_w = rot_right(pre_rot_w, ctl.twice);
      2'b01:   post_rot_w = rot_left(pre_rot_w, ctl.twice);
      2'b00:   post_rot_w = ctl.twice ? {inc_link_w, swap_acc_w} : pre_rot_w;
      default: post_rot_w = pre_rot_w;
    endcase
  end

  assign acc_o  = post_rot_w[DATA_W-1:0];
  assign link_o = post_rot_w[ROT_W-1];
endmodule

// File: rtl/opr_group2.sv
module opr_group2
  import opr_pkg::*;
(
  input  g2_ctl_t           ctl,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              skip_o,
  output logic              stop_o
);
  logic hit_neg_w, hit_zero_w, hit_link_w, any_hit_w;
  logic [DATA_W-1:0] clr_acc_w;

  // step 1: tests on incoming state
  assign hit_neg_w  = ctl.sel_neg  & acc_i[DATA_W-1];
  assign hit_zero_w = ctl.sel_zero & (acc_i == '0);
  assign hit_link_w = ctl.sel_link & link_i;
  assign any_hit_w  = hit_neg_w | hit_zero_w | hit_link_w;
  assign skip_o     = ctl.invert ? ~any_hit_w : any_hit_w;

  // step 2: clear
  assign clr_acc_w  = ctl.clr_acc ? '0 : acc_i;

  // step 3: switch merge and stop
  assign acc_o  = clr_acc_w | (ctl.or_sw ? sw_i : '0);
  assign stop_o = ctl.stop;
endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
#(
  parameter int unsigned DW = opr_pkg::DATA_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [11:0]   instr,
  input  logic [DW-1:0] acc_in,
  input  logic          link_in,
  input  logic [DW-1:0] switches,
  output logic [DW-1:0] acc_out,
  output logic          link_out,
  output logic          skip,
  output logic          halt,
  output logic          unimpl,
  output logic          done
);
  opr_grp_e          grp_w;
  g1_ctl_t           g1_w;
  g2_ctl_t           g2_w;
  logic [DW-1:0]     g1_acc_w, g2_acc_w;
  logic              g1_link_w, g2_skip_w, g2_stop_w;
  logic [DW-1:0]     nxt_acc;
  logic              nxt_link, nxt_skip, nxt_halt, nxt_unimpl;

  opr_decode u_dec (.instr(instr), .grp(grp_w), .g1(g1_w), .g2(g2_w));

  opr_group1 u_g1 (
    .ctl(g1_w), .acc_i(acc_in), .link_i(link_in),
    .acc_o(g1_acc_w), .link_o(g1_link_w)
  );

  opr_group2 u_g2 (
    .ctl(g2_w), .acc_i(acc_in), .link_i(link_in), .sw_i(switches),
    .acc_o(g2_acc_w), .skip_o(g2_skip_w), .stop_o(g2_stop_w)
  );

  always_comb begin
    nxt_acc    = acc_in;
    nxt_link   = link_in;
    nxt_skip   = 1'b0;
    nxt_halt   = 1'b0;
    nxt_unimpl = 1'b0;
    unique case (grp_w)
      GRP_ONE: begin
        nxt_acc  = g1_acc_w;
        nxt_link = g1_link_w;
      end
      GRP_TWO: begin
        nxt_acc  = g2_acc_w;
        nxt_skip = g2_skip_w;
        nxt_halt = g2_stop_w;
      end
      GRP_THREE: nxt_unimpl = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out  <= '0;
      link_out <= 1'b0;
      skip     <= 1'b0;
      halt     <= 1'b0;
      unimpl   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done   <= issue;
      skip   <= issue & nxt_skip;
      halt   <= issue & nxt_halt;
      unimpl <= issue & nxt_unimpl;
      if (issue) begin
        acc_out  <= nxt_acc;
        link_out <= nxt_link;
      end
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!done && !skip && !halt && !unimpl));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(acc_out) && $stable(link_out)));
  // R3
  g3_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && grp_w == GRP_THREE) |=>
      (unimpl && !skip && !halt && acc_out == $past(acc_in) && link_out == $past(link_in)));
  // R12
  g1_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && grp_w == GRP_ONE) |=> (!skip && !halt && !unimpl));
  // R10
  uncond_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && grp_w == GRP_TWO && g2_w.invert &&
     !(g2_w.sel_neg || g2_w.sel_zero || g2_w.sel_link)) |=> skip);
  // R11
  g2_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && grp_w == GRP_TWO && !g2_w.clr_acc && !g2_w.or_sw) |=>
      (acc_out == $past(acc_in) && link_out == $past(link_in)));
  // R6
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr == 12'o7001 && acc_in == '1) |=>
      (acc_out == '0 && link_out == !$past(link_in)));
endmodule

// File: tb/test_opr_unit.sv
module test_opr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] acc_in = '0;
  logic        link_in = 1'b0;
  logic [11:0] switches = '0;
  logic [11:0] acc_out;
  logic        link_out, skip, halt, unimpl, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  opr_unit i_opr_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
    .acc_in(acc_in), .link_in(link_in), .switches(switches),
    .acc_out(acc_out), .link_out(link_out), .skip(skip),
    .halt(halt), .unimpl(unimpl), .done(done)
  );

  typedef struct packed {
    logic        unimpl;
    logic        halt;
    logic        skip;
    logic        link;
    logic [11:0] acc;
  } exp_t;

  // bench model, written from the requirements
  function automatic exp_t model(input logic [11:0] ir, input logic [11:0] a,
                                 input logic l, input logic [11:0] sw);
    exp_t e;
    logic [12:0] v;
    bit hit;
    e = '{unimpl: 0, halt: 0, skip: 0, link: l, acc: a};
    if (ir[11:9] != 3'o7) return e;
    if (ir[8] == 1'b0) begin
      if (ir & 12'o0200) e.acc = 12'o0000;
      if (ir & 12'o0100) e.link = 1'b0;
      if (ir & 12'o0040) e.acc = e.acc ^ 12'o7777;
      if (ir & 12'o0020) e.link = !e.link;
      if (ir & 12'o0001) begin
        if (e.acc == 12'o7777) e.link = !e.link;
        e.acc = (e.acc == 12'o7777) ? 12'o0000 : e.acc + 12'd1;
      end
      v = {e.link, e.acc};
      case ({ir[3], ir[2]})
        2'b10: for (int k = 0; k < (ir[1] ? 2 : 1); k++) v = {v[0], v[12:1]};
        2'b01: for (int k = 0; k < (ir[1] ? 2 : 1); k++) v = {v[11:0], v[12]};
        2'b00: if (ir[1]) v = {v[12], v[5:0], v[11:6]};
        default: ;
      endcase
      e.link = v[12];
      e.acc  = v[11:0];
    end else if (ir[0] == 1'b0) begin
      hit = 0;
      if (ir[6] && a[11])         hit = 1;
      if (ir[5] && a == 12'o0000) hit = 1;
      if (ir[4] && l)             hit = 1;
      e.skip = ir[3] ? !hit : hit;
      if (ir[7]) e.acc = 12'o0000;
      if (ir[2]) e.acc = e.acc | sw;
      e.halt = ir[1];
    end else begin
      e.unimpl = 1'b1;
    end
    return e;
  endfunction

  function automatic string tag_of(input logic [11:0] ir);
    if (ir[11:9] != 3'o7) return "R3";
    if (!ir[8])           return ir[3:1] != 3'b000 ? "R7" : "R4";
    if (ir[0])            return "R3";
    return ir[3] ? "R10" : "R9";
  endfunction

  task automatic compare(input exp_t e, input string tag);
    checks++;
    if (acc_out !== e.acc || link_out !== e.link || skip !== e.skip ||
        halt !== e.halt || unimpl !== e.unimpl || done !== 1'b1) begin
      fails++;
      $display("FAIL %s: instr=%o got acc=%o l=%b sk=%b h=%b u=%b d=%b exp acc=%o l=%b sk=%b h=%b u=%b d=1",
               tag, instr, acc_out, link_out, skip, halt, unimpl, done,
               e.acc, e.link, e.skip, e.halt, e.unimpl);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic run_op(input logic [11:0] ir, input logic [11:0] a, input logic l,
                        input logic [11:0] sw, input exp_t e, input string tag);
    instr = ir; acc_in = a; link_in = l; switches = sw; issue = 1'b1;
    @(negedge clk);
    compare(e, tag);
    issue = 1'b0;
  endtask

  task automatic run_dir(input logic [11:0] ir, input logic [11:0] a, input logic l,
                         input logic [11:0] sw, input logic [11:0] ea, input logic el,
                         input logic es, input logic eh, input logic eu, input string tag);
    exp_t e;
    e = '{unimpl: eu, halt: eh, skip: es, link: el, acc: ea};
    run_op(ir, a, l, sw, e, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] held_a;
    logic        held_l;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (acc_out !== 12'o0 || link_out !== 1'b0 || skip || halt || unimpl || done) begin
      fails++;
      $display("FAIL R1: got acc=%o l=%b sk=%b h=%b u=%b d=%b expected all zero",
               acc_out, link_out, skip, halt, unimpl, done);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R4 clears
    run_dir(12'o7300, 12'o5555, 1, 0, 12'o0000, 0, 0, 0, 0, "R4");
    // R5 complement after clear
    run_dir(12'o7240, 12'o1234, 0, 0, 12'o7777, 0, 0, 0, 0, "R5");
    run_dir(12'o7120, 12'o1234, 0, 0, 12'o1234, 1, 0, 0, 0, "R5");
    // R6 increment, carry and ordering after complement
    run_dir(12'o7001, 12'o7777, 0, 0, 12'o0000, 1, 0, 0, 0, "R6");
    run_dir(12'o7041, 12'o0001, 0, 0, 12'o7777, 0, 0, 0, 0, "R6");
    // R7 rotates
    run_dir(12'o7004, 12'o4000, 1, 0, 12'o0001, 1, 0, 0, 0, "R7");
    run_dir(12'o7010, 12'o0001, 0, 0, 12'o0000, 1, 0, 0, 0, "R7");
    run_dir(12'o7012, 12'o0003, 0, 0, 12'o4000, 1, 0, 0, 0, "R7");
    run_dir(12'o7006, 12'o2000, 0, 0, 12'o0000, 1, 0, 0, 0, "R7");
    // R8 halves exchange and both-rotate case
    run_dir(12'o7002, 12'o0077, 0, 0, 12'o7700, 0, 0, 0, 0, "R8");
    run_dir(12'o7014, 12'o1234, 1, 0, 12'o1234, 1, 0, 0, 0, "R8");
    run_dir(12'o7016, 12'o1234, 0, 0, 12'o1234, 0, 0, 0, 0, "R8");
    // R9 OR-sense skips
    run_dir(12'o7540, 12'o0000, 0, 0, 12'o0000, 0, 1, 0, 0, "R9");
    run_dir(12'o7540, 12'o0001, 0, 0, 12'o0001, 0, 0, 0, 0, "R9");
    run_dir(12'o7540, 12'o4000, 0, 0, 12'o4000, 0, 1, 0, 0, "R9");
    run_dir(12'o7420, 12'o0000, 1, 0, 12'o0000, 1, 1, 0, 0, "R9");
    // R10 AND-sense skips
    run_dir(12'o7410, 12'o0123, 0, 0, 12'o0123, 0, 1, 0, 0, "R10");
    run_dir(12'o7450, 12'o0000, 0, 0, 12'o0000, 0, 0, 0, 0, "R10");
    run_dir(12'o7510, 12'o4000, 0, 0, 12'o4000, 0, 0, 0, 0, "R10");
    run_dir(12'o7430, 12'o0000, 0, 0, 12'o0000, 0, 1, 0, 0, "R10");
    // R11 test before clear, then switch merge
    run_dir(12'o7640, 12'o0005, 0, 0, 12'o0000, 0, 0, 0, 0, "R11");
    run_dir(12'o7640, 12'o0000, 1, 0, 12'o0000, 1, 1, 0, 0, "R11");
    run_dir(12'o7604, 12'o7070, 0, 12'o1357, 12'o1357, 0, 0, 0, 0, "R11");
    run_dir(12'o7404, 12'o0400, 1, 12'o0012, 12'o0412, 1, 0, 0, 0, "R11");
    // R12 halt
    run_dir(12'o7402, 12'o0042, 0, 0, 12'o0042, 0, 0, 1, 0, "R12");
    // R3 third group and foreign opcode
    run_dir(12'o7401, 12'o3210, 1, 0, 12'o3210, 1, 0, 0, 1, "R3");
    run_dir(12'o1234, 12'o0707, 0, 12'o7777, 12'o0707, 0, 0, 0, 0, "R3");

    // R2 hold and quiet without issue
    run_dir(12'o7410, 12'o2222, 1, 0, 12'o2222, 1, 1, 0, 0, "R2");
    held_a = acc_out; held_l = link_out;
    acc_in = 12'o5151; link_in = 0; instr = 12'o7402;
    @(negedge clk);
    checks++;
    if (acc_out !== held_a || link_out !== held_l || skip || halt || unimpl || done) begin
      fails++;
      $display("FAIL R2: got acc=%o l=%b sk=%b h=%b u=%b d=%b expected acc=%o l=%b flags 0",
               acc_out, link_out, skip, halt, unimpl, done, held_a, held_l);
    end

    // constrained random, mostly operate words
    for (int n = 0; n < 600; n++) begin
      logic [11:0] ir, a, sw;
      logic        l;
      ir = ($urandom % 8 == 0) ? 12'($urandom) : {3'o7, 9'($urandom)};
      case ($urandom % 4)
        0: a = 12'o0000;
        1: a = 12'o7777;
        default: a = 12'($urandom);
      endcase
      l  = 1'($urandom);
      sw = 12'($urandom);
      run_op(ir, a, l, sw, model(ir, a, l, sw), tag_of(ir));
      if ($urandom % 3 == 0) @(negedge clk);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule